// File: doc/BRIEF.md
# Dual-Slope PWM Timer

This block is a symmetric pulse-width modulator for motor drives. An up/down counter climbs from zero to a programmable peak and then falls back to zero, so every PWM edge pair is centred on the peak. Each compare channel sets the position of those edges. Both the peak and the compare values are double-buffered. A value that software writes at any point in a period is applied only when the next period starts, so no period is ever asymmetric.

Each channel has a 2-bit output mode. The mode can disconnect the pin, give a level that is high while the count is below the compare value, give the inverse of that level, or give a level that is high only on the rising slope. The counter moves only on ticks of an external enable. A sticky overflow flag marks each return to zero. Each channel also has a sticky match flag. Software clears the flags through a write-one-to-clear mask.

The counter runs in two named states, RISE and FALL. It takes the transition RISE->FALL on the tick that brings the count to the peak, and the transition FALL->RISE on the tick that brings the count to zero. With a peak of zero it takes the self-loop RISE->RISE, and the count stays at zero. Each channel's output register has the states LOW and HIGH. On every clock it takes LOW->HIGH, HIGH->LOW or a self-loop, as the mode rule for the next count decides.

Top module: `dsp_pwm_timer`

## Requirements
- R1: On each tick the count moves by exactly one step. In RISE the count rises from 0 to the active peak, and it enters FALL on the tick that reaches the peak. In FALL the count falls, and it enters RISE on the tick that reaches 0. The count therefore equals the peak for exactly one tick. If the active peak is 0, the count stays at 0.
- R2: When `tick_i` is low, the count, the phase and both flags keep their values.
- R3: Mode encoding: 00 means off, 01 non-inverting, 10 inverting and 11 complementary. In mode 00, `pin_en_o` is 0 and `wave_o` is 0. Any other mode sets `pin_en_o` to 1.
- R4: In non-inverting mode the output follows the current count and compare value. In RISE it is high while count < compare. In FALL it is high while count <= compare. This means it is cleared at the match on the way up and set at the match on the way down.
- R5: In inverting mode the output is the complement of the R4 level.
- R6: In complementary mode the output is high only in RISE while count < compare. It is therefore cleared at the match and set again when the count reaches zero.
- R7: A compare write goes to a buffer. The active compare value takes the buffer contents on the tick that leaves zero in RISE.
- R8: A peak write goes to a buffer, which is loaded into the active peak on the same tick as R7. The reset value of the buffer and of the active peak is all ones.
- R9: In the non-inverting and inverting modes, a compare value of 0 gives a constant level for the whole period. So does a compare value of peak+1. Neither value produces a one-tick pulse.
- R10: The overflow flag is set on every tick after which the count is 0.
- R11: A channel's match flag is set on every tick after which the count equals that channel's active compare value.
- R12: Flags stay set until `flag_clr_i` has a 1 at their position. Bit 0 is overflow and bit k+1 is channel k. If a set and a clear of the same flag happen in the same cycle, the set wins.
- R13: Reset is synchronous. It gives count 0, phase RISE, all outputs low, all flags clear and all modes off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Counter advance enable |
| top_wr_i | input | 1 | Write strobe for the peak buffer |
| top_wdata_i | input | W | Peak value |
| cmp_wr_i | input | N | Per-channel write strobe for the compare buffer |
| cmp_wdata_i | input | W | Compare value |
| mode_wr_i | input | N | Per-channel write strobe for the output mode |
| mode_wdata_i | input | 2 | Output mode value |
| flag_clr_i | input | N+1 | Write-one-to-clear mask for the flags |
| count_o | output | W | Current count |
| wave_o | output | N | Per-channel waveform |
| pin_en_o | output | N | Per-channel pin enable |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | N | Sticky per-channel match flags |

## Verification
Some properties are checked on every clock. The count may move by at most one step per tick, and it must freeze when there is no tick. A channel that is switched off must keep its output low. A return to zero must leave the overflow flag set, and that flag must stay set unless it is cleared. Other behaviour can be shown only by the bench's scenarios. These are the exact placement of the edges in each mode, buffered peak and compare values waiting for the start of the next period, constant outputs at the compare extremes, and a set beating a clear in the same tick. The bench runs a cycle-accurate model alongside the design and compares against it.

// File: rtl/dsp_pwm_pkg.sv
package dsp_pwm_pkg;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'b00,
        OUT_NONINV = 2'b01,
        OUT_INV    = 2'b10,
        OUT_COMPL  = 2'b11
    } out_mode_e;

    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } phase_e;

    typedef enum logic {
        WV_LOW  = 1'b0,
        WV_HIGH = 1'b1
    } wave_e;

endpackage

// File: rtl/dsp_updown_ctr.sv
module dsp_updown_ctr
    import dsp_pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         tick_i,
    input  logic         top_wr_i,
    input  logic [W-1:0] top_wdata_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] count_nx_o,
    output phase_e       phase_nx_o,
    output logic         load_o
);

    localparam logic [W-1:0] PEAK_RST = '1;

    logic [W-1:0] top_buf_q, top_act_q, top_use;
    logic [W-1:0] cnt_q, cnt_d;
    phase_e       ph_q, ph_d;

    // start of a new period: leaving zero while rising
    assign load_o  = tick_i && (ph_q == PH_RISE) && (cnt_q == '0);
    assign top_use = load_o ? top_buf_q : top_act_q;

    always_comb begin
        cnt_d = cnt_q;
        ph_d  = ph_q;
        if (tick_i) begin
            unique case (ph_q)
                PH_RISE: begin
                    if (cnt_q < top_use) begin
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_d == top_use) ph_d = PH_FALL;
                    end
                end
                PH_FALL: begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_d == '0) ph_d = PH_RISE;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q     <= '0;
            ph_q      <= PH_RISE;
            top_buf_q <= PEAK_RST;
            top_act_q <= PEAK_RST;
        end else begin
            cnt_q <= cnt_d;
            ph_q  <= ph_d;
            if (load_o)   top_act_q <= top_buf_q;
            if (top_wr_i) top_buf_q <= top_wdata_i;
        end
    end

    assign count_o    = cnt_q;
    assign count_nx_o = cnt_d;
    assign phase_nx_o = ph_d;

endmodule

// File: rtl/dsp_cmp_channel.sv
module dsp_cmp_channel
    import dsp_pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic         cmp_wr_i,
    input  logic [W-1:0] cmp_wdata_i,
    input  logic         mode_wr_i,
    input  logic [1:0]   mode_wdata_i,
    input  logic [W-1:0] count_nx_i,
    input  phase_e       phase_nx_i,
    output logic         wave_o,
    output logic         pin_en_o,
    output logic         match_o
);

    logic [W-1:0] cmp_buf_q, cmp_act_q, cmp_use;
    out_mode_e    mode_q, mode_d;
    wave_e        wv_q, wv_d;
    logic         below, rise_below;

    assign cmp_use = load_i ? cmp_buf_q : cmp_act_q;
    assign mode_d  = mode_wr_i ? out_mode_e'(mode_wdata_i) : mode_q;

    // symmetric level: strict on the way up, inclusive on the way down
    assign rise_below = (phase_nx_i == PH_RISE) && (count_nx_i < cmp_use);
    assign below      = (phase_nx_i == PH_RISE) ? (count_nx_i < cmp_use)
                                                : (count_nx_i <= cmp_use);

    // next waveform state
    always_comb begin
        wv_d = WV_LOW;
        unique case (mode_d)
            OUT_OFF:    wv_d = WV_LOW;
            OUT_NONINV: if (below)      wv_d = WV_HIGH;
            OUT_INV:    if (!below)     wv_d = WV_HIGH;
            OUT_COMPL:  if (rise_below) wv_d = WV_HIGH;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wv_q      <= WV_LOW;
            mode_q    <= OUT_OFF;
            cmp_buf_q <= '0;
            cmp_act_q <= '0;
        end else begin
            wv_q   <= wv_d;
            mode_q <= mode_d;
            if (load_i)   cmp_act_q <= cmp_buf_q;
            if (cmp_wr_i) cmp_buf_q <= cmp_wdata_i;
        end
    end

    assign wave_o   = (wv_q == WV_HIGH);
    assign pin_en_o = (mode_q != OUT_OFF);
    assign match_o  = tick_i && (count_nx_i == cmp_use);

endmodule

// File: rtl/dsp_sticky_flags.sv
module dsp_sticky_flags #(
    parameter int NF = 3
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    output logic [NF-1:0] flag_o
);

    logic [NF-1:0] flag_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) flag_q <= '0;
        else       flag_q <= (flag_q & ~clr_i) | set_i;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/dsp_pwm_timer.sv
module dsp_pwm_timer
    import dsp_pwm_pkg::*;
#(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         tick_i,
    input  logic         top_wr_i,
    input  logic [W-1:0] top_wdata_i,
    input  logic [N-1:0] cmp_wr_i,
    input  logic [W-1:0] cmp_wdata_i,
    input  logic [N-1:0] mode_wr_i,
    input  logic [1:0]   mode_wdata_i,
    input  logic [N:0]   flag_clr_i,
    output logic [W-1:0] count_o,
    output logic [N-1:0] wave_o,
    output logic [N-1:0] pin_en_o,
    output logic         ovf_flag_o,
    output logic [N-1:0] cmp_flag_o
);

    localparam int NF = N + 1;

    logic [W-1:0]  count_nx;
    phase_e        phase_nx;
    logic          load;
    logic [N-1:0]  match;
    logic          bottom;
    logic [NF-1:0] flags;

    dsp_updown_ctr #(.W(W)) ctr_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .tick_i      (tick_i),
        .top_wr_i    (top_wr_i),
        .top_wdata_i (top_wdata_i),
        .count_o     (count_o),
        .count_nx_o  (count_nx),
        .phase_nx_o  (phase_nx),
        .load_o      (load)
    );

    for (genvar k = 0; k < N; k++) begin : g_chan
        dsp_cmp_channel #(.W(W)) chan_i (
            .clk_i        (clk_i),
            .rst_i        (rst_i),
            .tick_i       (tick_i),
            .load_i       (load),
            .cmp_wr_i     (cmp_wr_i[k]),
            .cmp_wdata_i  (cmp_wdata_i),
            .mode_wr_i    (mode_wr_i[k]),
            .mode_wdata_i (mode_wdata_i),
            .count_nx_i   (count_nx),
            .phase_nx_i   (phase_nx),
            .wave_o       (wave_o[k]),
            .pin_en_o     (pin_en_o[k]),
            .match_o      (match[k])
        );
    end

    assign bottom = tick_i && (count_nx == '0);

    dsp_sticky_flags #(.NF(NF)) flags_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .set_i  ({match, bottom}),
        .clr_i  (flag_clr_i),
        .flag_o (flags)
    );

    assign ovf_flag_o = flags[0];
    assign cmp_flag_o = flags[NF-1:1];

endmodule

// File: rtl/dsp_pwm_timer_chk.sv
module dsp_pwm_timer_chk #(
    parameter int W = 8,
    parameter int N = 2
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         tick_i,
    input logic [N:0]   flag_clr_i,
    input logic [W-1:0] count_o,
    input logic [N-1:0] wave_o,
    input logic [N-1:0] pin_en_o,
    input logic         ovf_flag_o
);

    p_single_step_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_i |=> ((count_o == $past(count_o) + 1'b1) ||
                    (count_o == $past(count_o) - 1'b1) ||
                    (count_o == $past(count_o))));

    p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> $stable(count_o));

    for (genvar k = 0; k < N; k++) begin : g_off
        p_off_quiet_r3: assert property (@(posedge clk_i) disable iff (rst_i)
            !pin_en_o[k] |-> !wave_o[k]);
    end

    p_bottom_flag_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_i ##1 (count_o == '0) |-> ovf_flag_o);

    p_flag_sticky_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        (ovf_flag_o && !flag_clr_i[0]) |=> ovf_flag_o);

endmodule

bind dsp_pwm_timer dsp_pwm_timer_chk #(.W(W), .N(N)) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .tick_i     (tick_i),
    .flag_clr_i (flag_clr_i),
    .count_o    (count_o),
    .wave_o     (wave_o),
    .pin_en_o   (pin_en_o),
    .ovf_flag_o (ovf_flag_o)
);

// File: tb/dsp_pwm_timer_tb_top.sv
module dsp_pwm_timer_tb_top;

    localparam int  W      = 8;
    localparam int  N      = 2;
    localparam time CLK_T  = 10ns;

    typedef struct {
        logic [W-1:0] cnt;
        logic [N-1:0] wave;
        logic [N-1:0] pen;
        logic [N-1:0] cf;
        logic         ovf;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_i = 1'b1;
    logic         tick_i = 1'b0;
    logic         top_wr_i = 1'b0;
    logic [W-1:0] top_wdata_i = '0;
    logic [N-1:0] cmp_wr_i = '0;
    logic [W-1:0] cmp_wdata_i = '0;
    logic [N-1:0] mode_wr_i = '0;
    logic [1:0]   mode_wdata_i = '0;
    logic [N:0]   flag_clr_i = '0;
    logic [W-1:0] count_o;
    logic [N-1:0] wave_o, pin_en_o, cmp_flag_o;
    logic         ovf_flag_o;

    int checks = 0;
    int errors = 0;
    exp_t sb_q[$];

    // staged stimulus
    logic         s_rst = 1'b1, s_tick = 1'b0, s_top_wr = 1'b0;
    logic [W-1:0] s_top_d = '0, s_cmp_d = '0;
    logic [N-1:0] s_cmp_wr = '0, s_mode_wr = '0;
    logic [1:0]   s_mode_d = '0;
    logic [N:0]   s_clr = '0;

    // reference model state
    logic [W-1:0] m_cnt, m_top_act, m_top_buf;
    logic         m_rise, m_ovf;
    logic [W-1:0] m_cmp_act [N];
    logic [W-1:0] m_cmp_buf [N];
    logic [1:0]   m_mode [N];
    logic [N-1:0] m_cf;

    always #(CLK_T/2) clk = ~clk;

    dsp_pwm_timer #(.W(W), .N(N)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst_i),
        .tick_i       (tick_i),
        .top_wr_i     (top_wr_i),
        .top_wdata_i  (top_wdata_i),
        .cmp_wr_i     (cmp_wr_i),
        .cmp_wdata_i  (cmp_wdata_i),
        .mode_wr_i    (mode_wr_i),
        .mode_wdata_i (mode_wdata_i),
        .flag_clr_i   (flag_clr_i),
        .count_o      (count_o),
        .wave_o       (wave_o),
        .pin_en_o     (pin_en_o),
        .ovf_flag_o   (ovf_flag_o),
        .cmp_flag_o   (cmp_flag_o)
    );

    // mode rules from R3..R6
    function automatic logic lvl(input logic [1:0] md, input logic [W-1:0] c,
                                 input logic rise, input logic [W-1:0] cmp);
        logic b;
        b = rise ? (c < cmp) : (c <= cmp);
        case (md)
            2'b01:   return b;
            2'b10:   return !b;
            2'b11:   return rise && (c < cmp);
            default: return 1'b0;
        endcase
    endfunction

    task automatic step(input string tag);
        exp_t e;
        @(negedge clk);
        rst_i = s_rst; tick_i = s_tick; top_wr_i = s_top_wr; top_wdata_i = s_top_d;
        cmp_wr_i = s_cmp_wr; cmp_wdata_i = s_cmp_d; mode_wr_i = s_mode_wr;
        mode_wdata_i = s_mode_d; flag_clr_i = s_clr;
        if (s_rst) begin
            m_cnt = '0; m_rise = 1'b1; m_top_act = '1; m_top_buf = '1;
            m_ovf = 1'b0; m_cf = '0;
            for (int k = 0; k < N; k++) begin
                m_cmp_act[k] = '0; m_cmp_buf[k] = '0; m_mode[k] = 2'b00;
            end
        end else begin
            if (s_tick) begin
                if (m_rise && m_cnt == '0) begin
                    m_top_act = m_top_buf;
                    for (int k = 0; k < N; k++) m_cmp_act[k] = m_cmp_buf[k];
                end
                if (m_rise) begin
                    if (m_top_act != '0) begin
                        m_cnt = m_cnt + 1'b1;
                        if (m_cnt == m_top_act) m_rise = 1'b0;
                    end
                end else begin
                    m_cnt = m_cnt - 1'b1;
                    if (m_cnt == '0) m_rise = 1'b1;
                end
            end
            if (s_top_wr) m_top_buf = s_top_d;
            for (int k = 0; k < N; k++) begin
                if (s_cmp_wr[k])  m_cmp_buf[k] = s_cmp_d;
                if (s_mode_wr[k]) m_mode[k] = s_mode_d;
            end
            m_ovf = (m_ovf & ~s_clr[0]) | (s_tick && m_cnt == '0);
            for (int k = 0; k < N; k++)
                m_cf[k] = (m_cf[k] & ~s_clr[k+1]) | (s_tick && m_cnt == m_cmp_act[k]);
        end
        e.cnt = m_cnt; e.ovf = m_ovf; e.cf = m_cf; e.tag = tag;
        for (int k = 0; k < N; k++) begin
            e.wave[k] = lvl(m_mode[k], m_cnt, m_rise, m_cmp_act[k]);
            e.pen[k]  = (m_mode[k] != 2'b00);
        end
        sb_q.push_back(e);
        s_top_wr = 1'b0; s_cmp_wr = '0; s_mode_wr = '0; s_clr = '0;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic cmp_field(input string tag, input string fld,
                             input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, fld, act, exp);
        end
    endtask

    // monitor: compare each result a quarter period after its edge
    always @(posedge clk) begin
        #(CLK_T/4);
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp_field(e.tag, "count",  count_o,                 e.cnt);
            cmp_field(e.tag, "wave",   W'(wave_o),              W'(e.wave));
            cmp_field(e.tag, "pin_en", W'(pin_en_o),            W'(e.pen));
            cmp_field(e.tag, "ovf",    W'(ovf_flag_o),          W'(e.ovf));
            cmp_field(e.tag, "cmpflg", W'(cmp_flag_o),          W'(e.cf));
        end
    end

    initial begin
        #(CLK_T * 100000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R13: reset state
        s_rst = 1'b1; run(3, "R13");
        s_rst = 1'b0; s_tick = 1'b0;
        // R2: configuration with no tick, counter must stay at 0
        s_top_wr = 1'b1; s_top_d = 8'd10;       step("R2");
        s_cmp_wr = 2'b01; s_cmp_d = 8'd4;       step("R2");
        s_cmp_wr = 2'b10; s_cmp_d = 8'd4;       step("R2");
        s_mode_wr = 2'b01; s_mode_d = 2'b01;    step("R3");
        s_mode_wr = 2'b10; s_mode_d = 2'b10;    step("R3");
        // R1 R4 R5 R11: two full periods, peak 10
        s_tick = 1'b1; run(44, "R1/R4/R5/R11");
        // R6 R7: complementary, compare written mid-period
        run(5, "R7");
        s_mode_wr = 2'b10; s_mode_d = 2'b11; s_cmp_wr = 2'b10; s_cmp_d = 8'd6;
        step("R6/R7");
        run(44, "R6/R7");
        // R9: compare extremes 0 and peak+1
        s_cmp_wr = 2'b01; s_cmp_d = 8'd0; step("R9");
        s_cmp_wr = 2'b10; s_cmp_d = 8'd11; step("R9");
        s_mode_wr = 2'b10; s_mode_d = 2'b01; step("R9");
        run(44, "R9");
        s_mode_wr = 2'b01; s_mode_d = 2'b10; step("R9");
        run(44, "R9");
        // R8: peak written mid-period, applied at next period
        run(3, "R8");
        s_top_wr = 1'b1; s_top_d = 8'd6; step("R8");
        run(40, "R8/R10");
        // R2: sparse ticks
        for (int i = 0; i < 20; i++) begin
            s_tick = i[0]; step("R2");
        end
        // R12: clear with no tick
        s_tick = 1'b0; s_clr = '1; step("R12");
        run(2, "R12");
        // R12: set and clear in the same tick, set wins
        s_tick = 1'b1;
        while (!(m_cnt == 8'd1 && !m_rise)) step("R10");
        s_clr = '1; step("R12");
        run(4, "R12");
        // R3: channel 0 switched off
        s_mode_wr = 2'b01; s_mode_d = 2'b00; step("R3");
        run(20, "R3");
        wait (sb_q.size() == 0);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule